// File: doc/BRIEF.md
# Periodic Memory CRC Scrubber

This block checks a small configuration memory over and over for corrupted contents. It reads every word through a synchronous read port with one cycle of latency and folds each word into a 32-bit CRC. At the end of every full pass over the memory it compares the result with a reference value, which is loaded when configuration completes. The outcome of the comparison goes into a 32-bit signature register, and a single error flag is derived from that register. The flag always reflects the most recent complete pass and no earlier one.

The reference register has two ways in. It is loaded in parallel on a configuration-done pulse. It can also be rewritten bit by bit through a serial scan port while the checker keeps running. Shifting in a wrong reference is how the detection path is tested in the field. The whole checker advances only on a clock enable, which a programmable divider derives from the input clock.

Top module: `crc_scrub_checker`

## Requirements
- R1: While reset is held and right after it, `sig_out` is zero, and `crc_err`, `pass_end` and `mem_rd` are low.
- R2: Before the first `cfg_done` pulse the block issues no memory read (`mem_rd` stays low).
- R3: A `cfg_done` pulse loads `ref_in` into the reference register, visible at once as `scan_out` = bit 0 of `ref_in`, and starts a new pass from address 0.
- R4: At each pass end, `sig_out` becomes the standard reflected CRC-32 of the memory contents XOR the reference. That CRC uses polynomial 0x04C11DB7 (shifted form 0xEDB88320), an initial value of 0xFFFFFFFF and a final XOR of 0xFFFFFFFF. Each 32-bit word is fed least significant bit first, in address order. `sig_out` is therefore zero when the contents match.
- R5: `crc_err` equals the OR of the bits of `sig_out`. Both change only in the cycle in which `pass_end` is high, so an error flag stays high throughout the following pass.
- R6: A clean pass that follows a failing pass drives `crc_err` low again.
- R7: While `scan_en` is high, each clock shifts the reference register right by one bit. `scan_in` enters at bit 31 and the old bit 0 leaves on `scan_out`. Reading continues during shifting, and the new reference applies to the next pass end.
- R8: With a divisor value D on `div_sel`, `mem_rd` pulses exactly once every D+1 clock cycles.
- R9: Read addresses run 0, 1, …, 2^ADDR_W−1 in order and then wrap to 0 without a gap.
- R10: In steady state `pass_end` is a single-cycle pulse, and exactly 2^ADDR_W reads are issued between two consecutive pulses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_done | input | 1 | Configuration-done pulse: load reference and start checking |
| ref_in | input | 32 | Pre-computed reference loaded on `cfg_done` |
| div_sel | input | DIV_W | Clock-enable divisor minus one |
| scan_en | input | 1 | Serial shift enable for the reference register |
| scan_in | input | 1 | Serial data into bit 31 of the reference |
| scan_out | output | 1 | Bit 0 of the reference register |
| mem_rd | output | 1 | Memory read strobe |
| mem_addr | output | ADDR_W | Memory read address |
| mem_rdata | input | 32 | Read data, valid the cycle after the strobe and held until the next one |
| sig_out | output | 32 | Signature: computed CRC XOR reference from the last pass |
| crc_err | output | 1 | Error flag for the last complete pass |
| pass_end | output | 1 | One-cycle pulse at the end of each pass |

## Verification
A table of four memory fills is used, each with its own divisor and with a reference offset from the true CRC by a known mask. The masks are zero, a single low bit, a single high bit and a dense pattern. Together they separate a correct CRC and comparison from an off-by-one word, a wrong bit order and a broken XOR, and they exercise the divisor at several ratios. Directed steps then flip a memory bit between passes to show that an error appears and later clears. They shift a new reference in during operation to show that injection works without a restart, and they check the idle and reset state.

// File: rtl/crcchk_pkg.sv
// Shared constants and the word-wide CRC step for the memory scrubber.
// Assumes the reflected CRC-32 form, fed LSB first.
package crcchk_pkg;
    localparam int          CRC_W     = 32;
    localparam logic [31:0] CRC_POLY  = 32'hEDB88320;
    localparam logic [31:0] CRC_INIT  = 32'hFFFFFFFF;
    localparam logic [31:0] CRC_XOUT  = 32'hFFFFFFFF;

    // Fold one 32-bit word into a running CRC, least significant bit first.
    function automatic logic [31:0] crc_step(input logic [31:0] crc_in,
                                             input logic [31:0] word);
        logic [31:0] c;
        c = crc_in;
        for (int b = 0; b < CRC_W; b++) begin
            if (c[0] ^ word[b]) c = (c >> 1) ^ CRC_POLY;
            else                c = c >> 1;
        end
        return c;
    endfunction
endpackage

// File: rtl/crcchk_clk_div.sv
// Programmable clock-enable generator. Pulses ce once every div_sel+1 cycles.
// sync_clr restarts the count so pacing after a restart is deterministic.
module crcchk_clk_div #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sync_clr,
    input  logic [DIV_W-1:0] div_sel,
    output logic             ce
);
    logic [DIV_W-1:0] cnt_q;

    assign ce = (cnt_q >= div_sel);

    // Count up to the divisor and wrap on the enable cycle.
    always_ff @(posedge clk) begin
        if (!rst_n || sync_clr) cnt_q <= '0;
        else if (ce)            cnt_q <= '0;
        else                    cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/crcchk_ref_store.sv
// Reference register: parallel load on configuration, serial shift for injection.
// A parallel load wins over a shift in the same cycle.
module crcchk_ref_store (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        load,
    input  logic [31:0] load_val,
    input  logic        shift_en,
    input  logic        shift_in,
    output logic [31:0] ref_q,
    output logic        shift_out
);
    assign shift_out = ref_q[0];

    // Load or shift right with new bits entering at the top.
    always_ff @(posedge clk) begin
        if (!rst_n)        ref_q <= '0;
        else if (load)     ref_q <= load_val;
        else if (shift_en) ref_q <= {shift_in, ref_q[31:1]};
    end
endmodule

// File: rtl/crcchk_engine.sv
// Pass sequencer and CRC accumulator. Issues one read per enable, absorbs the
// word read at the previous enable, and closes a pass after the last address.
// Assumes read data updates only on a strobe and is held until the next one.
module crcchk_engine
    import crcchk_pkg::*;
#(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              ce,
    input  logic [31:0]       ref_val,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic [31:0]       sig,
    output logic              err,
    output logic              pass_end
);
    localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

    logic              run_q;
    logic [ADDR_W-1:0] addr_q;
    logic              vld_q;
    logic              last_q;
    logic [31:0]       crc_q;
    logic [31:0]       crc_nx;
    logic [31:0]       diff;

    assign mem_rd   = run_q & ce;
    assign mem_addr = addr_q;

    // Next CRC after the held word, and its mismatch against the reference.
    always_comb begin
        crc_nx = crc_step(crc_q, mem_rdata);
        diff   = (crc_nx ^ CRC_XOUT) ^ ref_val;
    end

    // Sequence addresses, accumulate the CRC and publish the result per pass.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            run_q    <= 1'b0;
            addr_q   <= '0;
            vld_q    <= 1'b0;
            last_q   <= 1'b0;
            crc_q    <= CRC_INIT;
            sig      <= '0;
            err      <= 1'b0;
            pass_end <= 1'b0;
        end else begin
            pass_end <= 1'b0;
            if (start) begin
                run_q  <= 1'b1;
                addr_q <= '0;
                vld_q  <= 1'b0;
                last_q <= 1'b0;
                crc_q  <= CRC_INIT;
            end else if (mem_rd) begin
                addr_q <= addr_q + 1'b1;
                vld_q  <= 1'b1;
                last_q <= (addr_q == LAST_ADDR);
                if (vld_q) begin
                    if (last_q) begin
                        sig      <= diff;
                        err      <= |diff;
                        pass_end <= 1'b1;
                        crc_q    <= CRC_INIT;
                    end else begin
                        crc_q    <= crc_nx;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/crc_scrub_checker.sv
// Top of the periodic memory CRC scrubber: divider, reference register and
// pass engine. Assumes cfg_done is a single-cycle pulse.
module crc_scrub_checker #(
    parameter int ADDR_W = 4,
    parameter int DIV_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_done,
    input  logic [31:0]       ref_in,
    input  logic [DIV_W-1:0]  div_sel,
    input  logic              scan_en,
    input  logic              scan_in,
    output logic              scan_out,
    output logic              mem_rd,
    output logic [ADDR_W-1:0] mem_addr,
    input  logic [31:0]       mem_rdata,
    output logic [31:0]       sig_out,
    output logic              crc_err,
    output logic              pass_end
);
    logic        ce;
    logic [31:0] ref_q;

    crcchk_clk_div #(.DIV_W(DIV_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .sync_clr (cfg_done),
        .div_sel  (div_sel),
        .ce       (ce)
    );

    crcchk_ref_store u_ref (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (cfg_done),
        .load_val  (ref_in),
        .shift_en  (scan_en),
        .shift_in  (scan_in),
        .ref_q     (ref_q),
        .shift_out (scan_out)
    );

    crcchk_engine #(.ADDR_W(ADDR_W)) u_eng (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (cfg_done),
        .ce        (ce),
        .ref_val   (ref_q),
        .mem_rd    (mem_rd),
        .mem_addr  (mem_addr),
        .mem_rdata (mem_rdata),
        .sig       (sig_out),
        .err       (crc_err),
        .pass_end  (pass_end)
    );
endmodule

// File: rtl/crcchk_checker.sv
// Property checker for the scrubber top, attached by bind.
// Tracks its own expected address and start state.
module crcchk_checker #(
    parameter int ADDR_W = 4,
    parameter int DIV_W  = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_done,
    input logic [DIV_W-1:0]  div_sel,
    input logic              mem_rd,
    input logic [ADDR_W-1:0] mem_addr,
    input logic [31:0]       sig_out,
    input logic              crc_err,
    input logic              pass_end
);
    logic              started_q;
    logic [ADDR_W-1:0] exp_addr_q;

    // Remember whether checking has begun and which address comes next.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            started_q  <= 1'b0;
            exp_addr_q <= '0;
        end else if (cfg_done) begin
            started_q  <= 1'b1;
            exp_addr_q <= '0;
        end else if (mem_rd) begin
            exp_addr_q <= exp_addr_q + 1'b1;
        end
    end

    a_r2_idle_no_read: assert property (@(posedge clk) disable iff (!rst_n)
        !started_q |-> !mem_rd);

    a_r9_addr_order: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !cfg_done) |-> (mem_addr == exp_addr_q));

    a_r5_flag_follows_sig: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err == (sig_out != 32'd0));

    a_r5_sig_only_at_end: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sig_out) |-> pass_end);

    a_r10_end_single: assert property (@(posedge clk) disable iff (!rst_n)
        pass_end |=> !pass_end);

    a_r8_rd_spacing: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd && !cfg_done && div_sel != '0) |=> (!mem_rd || !$stable(div_sel)));
endmodule

bind crc_scrub_checker crcchk_checker #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_done (cfg_done),
    .div_sel  (div_sel),
    .mem_rd   (mem_rd),
    .mem_addr (mem_addr),
    .sig_out  (sig_out),
    .crc_err  (crc_err),
    .pass_end (pass_end)
);

// File: tb/crc_scrub_checker_test.sv
module crc_scrub_checker_test;
    localparam int ADDR_W = 4;
    localparam int DIV_W  = 8;
    localparam int DEPTH  = 1 << ADDR_W;

    // seed[71:40], divisor[39:32], reference offset mask[31:0]
    localparam logic [71:0] VECS [4] = '{
        {32'h12345678, 8'd0, 32'hDEADBEEF},
        {32'hA5A50F0F, 8'd3, 32'h00000001},
        {32'h0BADF00D, 8'd2, 32'h80000000},
        {32'h5EED0001, 8'd1, 32'h00000000}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_done = 1'b0;
    logic [31:0]       ref_in = '0;
    logic [DIV_W-1:0]  div_sel = '0;
    logic              scan_en = 1'b0;
    logic              scan_in = 1'b0;
    logic              scan_out;
    logic              mem_rd;
    logic [ADDR_W-1:0] mem_addr;
    logic [31:0]       mem_rdata = '0;
    logic [31:0]       sig_out;
    logic              crc_err;
    logic              pass_end;

    logic [31:0] mem [DEPTH];
    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    crc_scrub_checker #(.ADDR_W(ADDR_W), .DIV_W(DIV_W)) uut (.*);

    // Memory model: one-cycle read, data held between strobes.
    always @(posedge clk) if (mem_rd) mem_rdata <= mem[mem_addr];

    function automatic logic [31:0] gold_crc();
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < DEPTH; i++)
            for (int b = 0; b < 32; b++)
                c = (c[0] ^ mem[i][b]) ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        return c ^ 32'hFFFFFFFF;
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Port monitors: address order, read spacing, reads per pass.
    int cyc = 0, last_rd = 0, rd_in_pass = 0;
    int addr_bad = 0, gap_bad = 0, count_bad = 0, scan_reads = 0;
    bit seen_rd = 0, first_pass = 1;
    logic [ADDR_W-1:0] exp_addr = '0;
    always begin
        @(negedge clk);
        #1;
        cyc++;
        if (cfg_done) begin
            exp_addr = '0; seen_rd = 0; first_pass = 1; rd_in_pass = 0;
        end else begin
            if (pass_end) begin
                if (!first_pass && rd_in_pass != DEPTH) count_bad++;
                first_pass = 0;
                rd_in_pass = 0;
            end
            if (mem_rd) begin
                if (mem_addr != exp_addr) addr_bad++;
                if (seen_rd && (cyc - last_rd) != int'(div_sel) + 1) gap_bad++;
                exp_addr = exp_addr + 1'b1;
                last_rd = cyc; seen_rd = 1; rd_in_pass++;
                if (scan_en) scan_reads++;
            end
        end
    end

    task automatic wait_end();
        int t = 0;
        @(negedge clk);
        while (!pass_end && t < 4000) begin @(negedge clk); t++; end
        if (t >= 4000) check(0, "R10 timeout", 0, 1);
    endtask

    task automatic configure(input logic [31:0] r);
        @(negedge clk);
        ref_in = r; cfg_done = 1'b1;
        @(negedge clk);
        cfg_done = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            n_fail++; n_chk++;
            $display("FAIL watchdog: actual hung expected done");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] good, x, old;
        bit rd_seen;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(sig_out == 0 && !crc_err && !pass_end && !mem_rd, "R1 reset", sig_out, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(sig_out == 0 && !crc_err && !pass_end, "R1 after reset", sig_out, 0);
        // R2: no reads before configuration
        rd_seen = 0;
        for (int i = 0; i < 20; i++) begin @(negedge clk); if (mem_rd) rd_seen = 1; end
        check(!rd_seen, "R2 idle read", rd_seen, 0);

        // R4 R5 R8: table walk
        for (int v = 0; v < 4; v++) begin
            for (int i = 0; i < DEPTH; i++)
                mem[i] = VECS[v][71:40] + i * 32'h9E3779B9;
            good = gold_crc();
            div_sel = VECS[v][39:32];
            configure(good ^ VECS[v][31:0]);
            check(scan_out == ref_in[0], "R3 load", scan_out, ref_in[0]);
            for (int p = 0; p < 2; p++) begin
                wait_end();
                check(sig_out == VECS[v][31:0], "R4 signature", sig_out, VECS[v][31:0]);
                check(crc_err == (VECS[v][31:0] != 0), "R5 flag", crc_err, VECS[v][31:0] != 0);
            end
        end
        check(gap_bad == 0, "R8 read spacing", gap_bad, 0);

        // R5 R6: corrupt one word, then restore
        wait_end();
        mem[5] = mem[5] ^ 32'h00000100;
        x = gold_crc() ^ good;
        wait_end();
        check(sig_out == x && crc_err, "R5 corruption seen", sig_out, x);
        mem[5] = mem[5] ^ 32'h00000100;
        repeat (6) @(negedge clk);
        check(crc_err == 1'b1, "R5 flag held mid-pass", crc_err, 1);
        wait_end();
        check(sig_out == 0 && !crc_err, "R6 clean again", sig_out, 0);

        // R7: serial injection while running
        old = good; x = good ^ 32'h00010000;
        scan_reads = 0;
        for (int b = 0; b < 32; b++) begin
            @(negedge clk);
            if (scan_out != old[b]) check(0, "R7 scan_out", scan_out, old[b]);
            scan_en = 1'b1; scan_in = x[b];
        end
        @(negedge clk);
        scan_en = 1'b0;
        check(scan_out == x[0], "R7 shifted value", scan_out, x[0]);
        check(scan_reads > 0, "R7 running during shift", scan_reads, 1);
        wait_end();
        check(sig_out == 32'h00010000 && crc_err, "R7 injected error", sig_out, 32'h00010000);

        check(addr_bad == 0, "R9 address order", addr_bad, 0);
        check(count_bad == 0, "R10 reads per pass", count_bad, 0);
        @(negedge clk);
        check(!pass_end, "R10 single pulse", pass_end, 0);

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule